// File: doc/BRIEF.md
# Flash Write State Machine Status Tracker

This block tracks the embedded program/erase engine of a boot-block NOR flash. It reports that engine through an 8-bit status byte and a live busy line. It takes decoded commands: program, block erase, erase suspend, program suspend, resume and clear-status. It also takes a programming-supply-good flag, the write-protect pin level, a per-block lock map and a pass/fail outcome that stands in for the cell array. Each operation runs as a sequence of timed pulses. After each pulse the array outcome decides one of three results: success, a retry, or a final failure once the pulse budget is spent.

The sequencer has five named states. `ST_READY` is idle, showing read status. `ST_PROG_RUN` and `ST_ERASE_RUN` mean an operation is in progress. `ST_PROG_PARK` and `ST_ERASE_PARK` mean an operation is suspended. The transitions are as follows:
- *launch*: `ST_READY` to a run state, on a program or erase command that passes the supply and lock checks.
- *abort*: `ST_READY` stays in `ST_READY` and sets flags, when a check fails.
- *finish*: a run state to `ST_READY`, on a passing pulse or on the last failing pulse.
- *retry*: a run state stays in that run state, after a failing pulse that is not the last.
- *park*: a run state to its matching park state, on the matching suspend command.
- *unpark*: a park state to its run state, on resume.

The host does not see the live status directly. The byte on the bus is captured only when the read strobe (chip enable and output enable both low) becomes active. To see a finished operation, the host must strobe again.

Top module: `fwsm_status_top`

## Requirements
- R1: After reset the live status reads ready (bit 7 = 1) and `busy` is 0. A program (`cmd_op` = 1) or erase (`cmd_op` = 2) accepted in `ST_READY` with the supply good and no lock hit drives bit 7 to 0 and `busy` to 1 from the next cycle.
- R2: Each pulse lasts `PROG_CYC` (program) or `ERASE_CYC` (erase) cycles. If the first pulse passes, `busy` stays high for exactly that many cycles, and the status then reads 0x80.
- R3: `status_q` resets to 0x80. It loads the live status only in the first cycle in which `ce_n` and `oe_n` are both low, and holds in all other cycles. Bit 0 always reads 0.
- R4: Erase suspend (`cmd_op` = 3) during an erase parks it. Bits 6 and 7 read 1 and `busy` is 0 until a resume.
- R5: Program suspend (`cmd_op` = 4) during a program parks it. Bits 2 and 7 read 1 and `busy` is 0 until a resume.
- R6: Resume (`cmd_op` = 5) clears the suspend bit and returns bit 7 to 0. The operation continues from its remaining time, so its total busy cycles equal those of an uninterrupted run. A suspend that arrives in the cycle in which the operation completes is ignored.
- R7: If all `ERASE_MAX` erase pulses fail, bit 5 (bit 5 value 0x20) is set after `ERASE_MAX*ERASE_CYC` busy cycles.
- R8: If all `PROG_MAX` program pulses fail, bit 4 (value 0x10) is set after `PROG_MAX*PROG_CYC` busy cycles.
- R9: A program or erase issued while `vpp_ok` is 0 aborts with no busy cycle and sets bit 3 (0x08).
- R10: A program or erase to a block whose `lock_map` bit is 1 while `wp_n` is 0 aborts with no busy cycle and sets bit 1 (0x02). With `wp_n` = 1, or with an unlocked block, the operation runs and bit 1 stays 0. A low supply and a lock hit on the same command set both bits.
- R11: Bits 5, 4, 3 and 1 persist through later operations. Clear-status (`cmd_op` = 6) clears them.
- R12: A program or erase issued while busy or parked, a suspend of the other kind, and a resume while not parked are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code: 1 program, 2 erase, 3 erase suspend, 4 program suspend, 5 resume, 6 clear status |
| cmd_block | input | BLK_W | Target block index |
| vpp_ok | input | 1 | Programming supply above lockout |
| wp_n | input | 1 | Write-protect pin level; low enforces block locks |
| lock_map | input | NUM_BLOCKS | Per-block lock bits |
| array_pass | input | 1 | Array outcome at the end of a pulse |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| status_q | output | 8 | Bus-visible status byte |
| busy | output | 1 | Live busy indication |

## Verification
Two things can meet in one cycle, and the directed tests provoke both. The first is a suspend command that lands on the final cycle of a passing erase. The bench counts exactly `ERASE_CYC` busy cycles before issuing the suspend, and then expects `busy` low with a captured status of 0x80 and bit 6 clear, because completion wins. The second is a single erase command that meets both a low supply and a locked block under active write-protect. That command must set bits 3 and 1 together (0x8A) without any busy cycle.

// File: rtl/fwsm_pkg.sv
package fwsm_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_PROGRAM    = 3'd1,
        CMD_ERASE      = 3'd2,
        CMD_ERASE_SUSP = 3'd3,
        CMD_PROG_SUSP  = 3'd4,
        CMD_RESUME     = 3'd5,
        CMD_CLEAR      = 3'd6
    } fwsm_cmd_e;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PROG_RUN,
        ST_ERASE_RUN,
        ST_PROG_PARK,
        ST_ERASE_PARK
    } fwsm_state_e;

    typedef struct packed {
        logic ready;
        logic erase_parked;
        logic erase_err;
        logic prog_err;
        logic supply_err;
        logic prog_parked;
        logic lock_err;
        logic rsvd;
    } fwsm_status_t;

endpackage

// File: rtl/fwsm_guard.sv
module fwsm_guard #(
    parameter int NUM_BLOCKS = 8,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic [BLK_W-1:0]      block,
    input  logic [NUM_BLOCKS-1:0] lock_map,
    input  logic                  wp_n,
    input  logic                  vpp_ok,
    output logic                  lock_hit,
    output logic                  vpp_low
);

    logic [NUM_BLOCKS-1:0] guarded;

    // a lock only bites while the protect pin is held low
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_guard
        assign guarded[b] = lock_map[b] & ~wp_n;
    end

    always_comb begin
        lock_hit = 1'b0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (block == BLK_W'(b)) lock_hit = guarded[b];
        end
    end

    assign vpp_low = ~vpp_ok;

endmodule

// File: rtl/fwsm_pulse_timer.sv
module fwsm_pulse_timer #(
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    parameter int PROG_MAX  = 4,
    parameter int ERASE_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_erase,
    input  logic retry,
    input  logic run_en,
    output logic tmr_zero,
    output logic last_pulse
);

    localparam int CYC_TOP = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int PUL_TOP = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
    localparam int TMR_W   = $clog2(CYC_TOP + 1);
    localparam int PCNT_W  = $clog2(PUL_TOP + 1);
    localparam logic [TMR_W-1:0]  PROG_LOAD  = TMR_W'(PROG_CYC - 1);
    localparam logic [TMR_W-1:0]  ERASE_LOAD = TMR_W'(ERASE_CYC - 1);
    localparam logic [PCNT_W-1:0] PROG_LIM   = PCNT_W'(PROG_MAX);
    localparam logic [PCNT_W-1:0] ERASE_LIM  = PCNT_W'(ERASE_MAX);

    logic [TMR_W-1:0]  tmr;
    logic [PCNT_W-1:0] pcnt;
    logic              op_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            pcnt     <= '0;
            op_erase <= 1'b0;
        end else if (start) begin
            tmr      <= start_erase ? ERASE_LOAD : PROG_LOAD;
            pcnt     <= PCNT_W'(1);
            op_erase <= start_erase;
        end else if (retry) begin
            tmr      <= op_erase ? ERASE_LOAD : PROG_LOAD;
            pcnt     <= pcnt + PCNT_W'(1);
        end else if (run_en && tmr != '0) begin
            tmr      <= tmr - TMR_W'(1);
        end
    end

    assign tmr_zero   = (tmr == '0);
    assign last_pulse = (pcnt == (op_erase ? ERASE_LIM : PROG_LIM));

    AST_TIMER_FROZEN_WHILE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !retry && !run_en) |=> $stable(tmr)); // R6

endmodule

// File: rtl/fwsm_seq.sv
module fwsm_seq
    import fwsm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  fwsm_cmd_e    cmd,
    input  logic         vpp_low,
    input  logic         lock_hit,
    input  logic         array_pass,
    input  logic         tmr_zero,
    input  logic         last_pulse,
    output logic         start,
    output logic         start_erase,
    output logic         retry,
    output logic         run_en,
    output logic         busy,
    output fwsm_status_t status
);

    fwsm_state_e state, state_nx;

    logic op_cmd, esusp_cmd, psusp_cmd, resume_cmd, clear_cmd;
    logic in_prog, in_erase, active, done_now;
    logic prog_fail, erase_fail;
    logic prog_err_q, erase_err_q, supply_err_q, lock_err_q;

    // command and condition decode
    always_comb begin
        op_cmd     = cmd_valid && (cmd == CMD_PROGRAM || cmd == CMD_ERASE);
        esusp_cmd  = cmd_valid && (cmd == CMD_ERASE_SUSP);
        psusp_cmd  = cmd_valid && (cmd == CMD_PROG_SUSP);
        resume_cmd = cmd_valid && (cmd == CMD_RESUME);
        clear_cmd  = cmd_valid && (cmd == CMD_CLEAR);
        in_prog    = (state == ST_PROG_RUN);
        in_erase   = (state == ST_ERASE_RUN);
        active     = in_prog || in_erase;
        done_now   = active && tmr_zero && (array_pass || last_pulse);
        prog_fail  = in_prog  && tmr_zero && !array_pass && last_pulse;
        erase_fail = in_erase && tmr_zero && !array_pass && last_pulse;
        start       = (state == ST_READY) && op_cmd && !vpp_low && !lock_hit;
        start_erase = (cmd == CMD_ERASE);
        retry       = active && tmr_zero && !array_pass && !last_pulse;
        run_en      = active;
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (start) state_nx = start_erase ? ST_ERASE_RUN : ST_PROG_RUN;
            end
            ST_PROG_RUN: begin
                if (done_now)       state_nx = ST_READY;
                else if (psusp_cmd) state_nx = ST_PROG_PARK;
            end
            ST_ERASE_RUN: begin
                if (done_now)       state_nx = ST_READY;
                else if (esusp_cmd) state_nx = ST_ERASE_PARK;
            end
            ST_PROG_PARK: begin
                if (resume_cmd) state_nx = ST_PROG_RUN;
            end
            ST_ERASE_PARK: begin
                if (resume_cmd) state_nx = ST_ERASE_RUN;
            end
            default: state_nx = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    // sticky error flags; a fresh set outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_err_q   <= 1'b0;
            erase_err_q  <= 1'b0;
            supply_err_q <= 1'b0;
            lock_err_q   <= 1'b0;
        end else begin
            if (clear_cmd) begin
                prog_err_q   <= 1'b0;
                erase_err_q  <= 1'b0;
                supply_err_q <= 1'b0;
                lock_err_q   <= 1'b0;
            end
            if (prog_fail)  prog_err_q  <= 1'b1;
            if (erase_fail) erase_err_q <= 1'b1;
            if (state == ST_READY && op_cmd && vpp_low)  supply_err_q <= 1'b1;
            if (state == ST_READY && op_cmd && lock_hit) lock_err_q   <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        status.ready        = !(state == ST_PROG_RUN || state == ST_ERASE_RUN);
        status.erase_parked = (state == ST_ERASE_PARK);
        status.erase_err    = erase_err_q;
        status.prog_err     = prog_err_q;
        status.supply_err   = supply_err_q;
        status.prog_parked  = (state == ST_PROG_PARK);
        status.lock_err     = lock_err_q;
        status.rsvd         = 1'b0;
        busy                = !status.ready;
    end

    AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && op_cmd && !vpp_low && !lock_hit) |=> !status.ready); // R1
    AST_ERASE_PARK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_erase && esusp_cmd && !done_now) |=> (status.erase_parked && status.ready)); // R4
    AST_PROG_PARK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && psusp_cmd && !done_now) |=> (status.prog_parked && status.ready)); // R5
    AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && op_cmd && vpp_low) |=> (status.supply_err && status.ready)); // R9
    AST_LOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && op_cmd && lock_hit) |=> (status.lock_err && status.ready)); // R10
    AST_ERASE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status.erase_err && !clear_cmd) |=> status.erase_err); // R11

endmodule

// File: rtl/fwsm_bus_latch.sv
module fwsm_bus_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] live,
    output logic [7:0] status_q
);

    logic strobe, strobe_prev, strobe_rise;

    assign strobe      = !ce_n && !oe_n;
    assign strobe_rise = strobe && !strobe_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
            status_q    <= 8'h80;
        end else begin
            strobe_prev <= strobe;
            if (strobe_rise) status_q <= live;
        end
    end

    AST_HOLD_OUTSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rise |=> $stable(status_q)); // R3

endmodule

// File: rtl/fwsm_status_top.sv
module fwsm_status_top
    import fwsm_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int PROG_CYC   = 6,
    parameter int ERASE_CYC  = 20,
    parameter int PROG_MAX   = 4,
    parameter int ERASE_MAX  = 3,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [BLK_W-1:0]      cmd_block,
    input  logic                  vpp_ok,
    input  logic                  wp_n,
    input  logic [NUM_BLOCKS-1:0] lock_map,
    input  logic                  array_pass,
    input  logic                  ce_n,
    input  logic                  oe_n,
    output logic [7:0]            status_q,
    output logic                  busy
);

    logic         lock_hit, vpp_low;
    logic         start, start_erase, retry, run_en;
    logic         tmr_zero, last_pulse;
    fwsm_status_t live;

    fwsm_guard #(.NUM_BLOCKS(NUM_BLOCKS)) u_guard (
        .block    (cmd_block),
        .lock_map (lock_map),
        .wp_n     (wp_n),
        .vpp_ok   (vpp_ok),
        .lock_hit (lock_hit),
        .vpp_low  (vpp_low)
    );

    fwsm_pulse_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_MAX  (PROG_MAX),
        .ERASE_MAX (ERASE_MAX)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_erase (start_erase),
        .retry       (retry),
        .run_en      (run_en),
        .tmr_zero    (tmr_zero),
        .last_pulse  (last_pulse)
    );

    fwsm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd         (fwsm_cmd_e'(cmd_op)),
        .vpp_low     (vpp_low),
        .lock_hit    (lock_hit),
        .array_pass  (array_pass),
        .tmr_zero    (tmr_zero),
        .last_pulse  (last_pulse),
        .start       (start),
        .start_erase (start_erase),
        .retry       (retry),
        .run_en      (run_en),
        .busy        (busy),
        .status      (live)
    );

    fwsm_bus_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .live     (live),
        .status_q (status_q)
    );

endmodule

// File: tb/fwsm_status_top_tb.sv
module fwsm_status_top_tb;

    localparam int NB   = 8;
    localparam int PCYC = 6;
    localparam int ECYC = 20;
    localparam int PMAX = 4;
    localparam int EMAX = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [2:0]    cmd_block = 3'd0;
    logic          vpp_ok = 1'b1;
    logic          wp_n = 1'b1;
    logic [NB-1:0] lock_map = '0;
    logic          array_pass = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [7:0]    status_q;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwsm_status_top #(
        .NUM_BLOCKS(NB), .PROG_CYC(PCYC), .ERASE_CYC(ECYC),
        .PROG_MAX(PMAX), .ERASE_MAX(EMAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_block(cmd_block), .vpp_ok(vpp_ok), .wp_n(wp_n), .lock_map(lock_map),
        .array_pass(array_pass), .ce_n(ce_n), .oe_n(oe_n),
        .status_q(status_q), .busy(busy)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [2:0] blk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_block = blk;
        step();
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic read_status(output logic [7:0] val);
        ce_n = 1'b0;
        oe_n = 1'b0;
        step();
        val  = status_q;
        ce_n = 1'b1;
        oe_n = 1'b1;
        step();
    endtask

    // counts busy cycles from the current one onward
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset();
        check(int'(status_q), 8'h80, "R3", "status after reset");
        check(int'(busy), 0, "R1", "busy after reset");
    endtask

    task automatic t_program_ok();
        int n;
        logic [7:0] s;
        array_pass = 1'b1;
        issue(3'd1, 3'd0);
        check(int'(busy), 1, "R1", "busy after program launch");
        count_busy(n);
        check(n, PCYC, "R2", "program busy cycles");
        read_status(s);
        check(int'(s), 8'h80, "R2", "status after program");
    endtask

    task automatic t_stale_capture();
        int n;
        logic [7:0] s;
        issue(3'd2, 3'd1);
        read_status(s);
        check(int'(s[7]), 0, "R1", "ready bit while erasing");
        count_busy(n);
        check(int'(status_q[7]), 0, "R3", "bus byte not refreshed without strobe");
        read_status(s);
        check(int'(s), 8'h80, "R3", "status after re-strobe");
    endtask

    task automatic t_erase_suspend();
        int pre, post;
        logic [7:0] s;
        issue(3'd2, 3'd2);
        pre = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            if (busy) pre++;
        end
        issue(3'd3, 3'd0);
        check(int'(busy), 0, "R4", "busy while erase parked");
        read_status(s);
        check(int'(s), 8'hC0, "R4", "status erase parked");
        repeat (10) step();
        issue(3'd1, 3'd0);
        issue(3'd4, 3'd0);
        check(int'(busy), 0, "R12", "program and program-suspend ignored while parked");
        read_status(s);
        check(int'(s), 8'hC0, "R4", "still parked after ignored commands");
        issue(3'd5, 3'd0);
        check(int'(busy), 1, "R6", "busy after resume");
        count_busy(post);
        check(pre + post, ECYC, "R6", "erase busy total across suspend");
        read_status(s);
        check(int'(s), 8'h80, "R6", "status after resumed erase");
    endtask

    task automatic t_program_suspend();
        int pre, post;
        logic [7:0] s;
        issue(3'd1, 3'd3);
        pre = 1;
        step();
        if (busy) pre++;
        issue(3'd3, 3'd0);
        check(int'(busy), 1, "R12", "erase suspend ignored during program");
        pre++;
        issue(3'd4, 3'd0);
        check(int'(busy), 0, "R5", "busy while program parked");
        read_status(s);
        check(int'(s), 8'h84, "R5", "status program parked");
        issue(3'd5, 3'd0);
        count_busy(post);
        check(pre + post, PCYC, "R6", "program busy total across suspend");
        read_status(s);
        check(int'(s), 8'h80, "R6", "suspend bit cleared after resume");
    endtask

    task automatic t_suspend_at_completion();
        int pre;
        logic [7:0] s;
        issue(3'd2, 3'd4);
        pre = 1;
        for (int i = 0; i < ECYC - 1; i++) begin
            step();
            if (busy) pre++;
        end
        check(pre, ECYC, "R2", "erase busy up to final cycle");
        issue(3'd3, 3'd0);
        check(int'(busy), 0, "R6", "completion beats coincident suspend");
        read_status(s);
        check(int'(s), 8'h80, "R6", "no parked bit after coincident suspend");
    endtask

    task automatic t_erase_fail();
        int n;
        logic [7:0] s;
        array_pass = 1'b0;
        issue(3'd2, 3'd0);
        count_busy(n);
        check(n, EMAX * ECYC, "R7", "erase failure busy cycles");
        read_status(s);
        check(int'(s), 8'hA0, "R7", "erase error bit");
        array_pass = 1'b1;
        issue(3'd6, 3'd0);
        read_status(s);
        check(int'(s), 8'h80, "R11", "clear after erase error");
    endtask

    task automatic t_program_fail();
        int n;
        logic [7:0] s;
        array_pass = 1'b0;
        issue(3'd1, 3'd0);
        count_busy(n);
        check(n, PMAX * PCYC, "R8", "program failure busy cycles");
        read_status(s);
        check(int'(s), 8'h90, "R8", "program error bit");
        array_pass = 1'b1;
        issue(3'd1, 3'd0);
        count_busy(n);
        read_status(s);
        check(int'(s), 8'h90, "R11", "program error sticky across success");
        issue(3'd6, 3'd0);
        read_status(s);
        check(int'(s), 8'h80, "R11", "clear after program error");
    endtask

    task automatic t_supply_abort();
        logic [7:0] s;
        vpp_ok = 1'b0;
        issue(3'd1, 3'd0);
        check(int'(busy), 0, "R9", "no busy on low supply");
        read_status(s);
        check(int'(s), 8'h88, "R9", "supply error bit");
        vpp_ok = 1'b1;
        issue(3'd6, 3'd0);
    endtask

    task automatic t_lock();
        int n;
        logic [7:0] s;
        lock_map = 8'b0000_1000;
        wp_n = 1'b0;
        issue(3'd2, 3'd3);
        check(int'(busy), 0, "R10", "no busy on locked block");
        read_status(s);
        check(int'(s), 8'h82, "R10", "lock error bit");
        issue(3'd6, 3'd0);
        wp_n = 1'b1;
        issue(3'd2, 3'd3);
        count_busy(n);
        check(n, ECYC, "R10", "locked block erases with protect high");
        read_status(s);
        check(int'(s), 8'h80, "R10", "no lock bit with protect high");
        wp_n = 1'b0;
        issue(3'd1, 3'd2);
        count_busy(n);
        check(n, PCYC, "R10", "unlocked block programs with protect low");
        vpp_ok = 1'b0;
        issue(3'd2, 3'd3);
        check(int'(busy), 0, "R10", "no busy on double abort");
        read_status(s);
        check(int'(s), 8'h8A, "R10", "supply and lock bits together");
        vpp_ok = 1'b1;
        wp_n = 1'b1;
        lock_map = '0;
        issue(3'd6, 3'd0);
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [7:0] s;
        issue(3'd5, 3'd0);
        check(int'(busy), 0, "R12", "resume ignored when idle");
        issue(3'd1, 3'd0);
        issue(3'd2, 3'd0);
        count_busy(n);
        check(1 + n, PCYC, "R12", "erase ignored during program");
        read_status(s);
        check(int'(s), 8'h80, "R12", "status after ignored commands");
        check(int'(s[0]), 0, "R3", "reserved bit reads 0");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_program_ok();
        t_stale_capture();
        t_erase_suspend();
        t_program_suspend();
        t_suspend_at_completion();
        t_erase_fail();
        t_program_fail();
        t_supply_abort();
        t_lock();
        t_busy_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule